// File: doc/BRIEF.md
# Location-Tracking TLB Lookup Unit

This block is a small fully associative translation buffer in which every entry, besides the page translation, keeps a location record for each cache line of its page. The record holds a 2-bit level code and a way index. A single lookup therefore yields both the physical address and a routing decision. The decision sends the access straight to one way of the first-level cache or the second-level cache, or straight to main memory. No tag compare and no probing of intermediate levels is needed.

The cache controllers keep the records current. They send an update message, made of a virtual page number, a line index, a new level and a new way, whenever a line is filled, evicted or moved. Lookups that miss in the buffer raise a refill request. The page-table walker answers through a refill port, and every freshly installed entry starts with all of its lines marked as not cached. Lookup results are registered and appear one cycle after the request.

Top module: `lttlb_top`

## Requirements
- R1: After synchronous reset, `rsp_valid`, `refill_req` and `upd_drop` are low and no entry is resident, so the first lookup misses.
- R2: `rsp_valid` is high exactly one cycle after `req_valid`. On a hit, `rsp_pa` is the entry's physical page number concatenated with the low 12 bits of the request address.
- R3: A lookup whose page is not resident gives `rsp_hit`=0 and `rsp_route`=00, and pulses `refill_req` in the same cycle with the request's page number on `refill_vpn`.
- R4: A refill installs the page with all 64 line records set to not cached, so every line routes to memory (00) until it is updated.
- R5: Route codes are 00 = memory, 01 = first-level cache, 10 = second-level cache. For 01 and 10, `rsp_way` is the recorded way. For 00, `rsp_way` is 0.
- R6: A recorded level code of 11 is reserved and is reported as route 00 (memory), with way 0.
- R7: An update to a resident page takes effect for lookups from the next cycle on. It changes only the addressed line; other lines of the page keep their records.
- R8: An update whose page is not resident changes no record and raises `upd_drop` for one cycle, one cycle after the update.
- R9: A lookup and an update to the same line in the same cycle return the record from before the update.
- R10: A refill fills an empty slot if one exists. Otherwise it replaces the least recently used entry, where both lookup hits and refills count as uses.
- R11: A refill of a page that is already resident reuses that entry's slot, replacing its physical page number and resetting its line records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to look up |
| upd_valid | input | 1 | Location-update strobe |
| upd_vpn | input | 20 | Page of the line being relocated |
| upd_line | input | 6 | Line index within the page |
| upd_level | input | 2 | New level code (00 none, 01 first level, 10 second level, 11 reserved) |
| upd_way | input | 3 | New way index |
| fill_valid | input | 1 | Refill strobe from the page walker |
| fill_vpn | input | 20 | Page number being installed |
| fill_ppn | input | 20 | Physical page number for it |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Page was resident |
| rsp_route | output | 2 | Destination: 00 memory, 01 first level, 10 second level |
| rsp_way | output | 3 | Way to read at that level |
| rsp_pa | output | 32 | Translated physical address (0 on a miss) |
| refill_req | output | 1 | Refill request on a miss |
| refill_vpn | output | 20 | Page number the refill is requested for |
| upd_drop | output | 1 | Previous update hit no resident page |

## Verification
On every cycle the assertions check the response timing against the request strobe. They also check that a miss always routes to memory together with a refill request, that the reserved code never appears as a route, that a memory route carries way 0, and that a drop flag only ever follows an update. The bench scenarios alone can show the stored content behind these outputs. That content covers records that persist and stay local to one line, the read-before-write result when a lookup and an update collide, line records cleared by a refill, slot reuse for a page that is already resident, and the choice of eviction victim once all sixteen slots are in use.

// File: rtl/lttlb_pkg.sv
package lttlb_pkg;
  localparam logic [1:0] LVL_NONE = 2'b00;
  localparam logic [1:0] LVL_L1   = 2'b01;
  localparam logic [1:0] LVL_L2   = 2'b10;
  localparam logic [1:0] LVL_RSV  = 2'b11;
  localparam int unsigned LVL_W   = 2;
endpackage

// File: rtl/lttlb_cam.sv
module lttlb_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            valid,
  input  logic [VPN_W-1:0]              key,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/lttlb_lru.sv
module lttlb_lru #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   victim
);
  logic [ENTRIES-1:0][IDX_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)            age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx])  age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (age_q[i] == IDX_W'(ENTRIES - 1)) victim = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lttlb_locmem.sv
module lttlb_locmem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 5,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lttlb_top.sv
module lttlb_top #(
  parameter int unsigned ENTRIES    = 16,
  parameter int unsigned VPN_W      = 20,
  parameter int unsigned PPN_W      = 20,
  parameter int unsigned PAGE_OFS_W = 12,
  parameter int unsigned LINE_OFS_W = 6,
  parameter int unsigned WAY_W      = 3,
  localparam int unsigned VA_W      = VPN_W + PAGE_OFS_W,
  localparam int unsigned PA_W      = PPN_W + PAGE_OFS_W,
  localparam int unsigned LINE_W    = PAGE_OFS_W - LINE_OFS_W,
  localparam int unsigned LINES     = 1 << LINE_W,
  localparam int unsigned IDX_W     = $clog2(ENTRIES),
  localparam int unsigned LVL_W     = lttlb_pkg::LVL_W,
  localparam int unsigned REC_W     = LVL_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              upd_valid,
  input  logic [VPN_W-1:0]  upd_vpn,
  input  logic [LINE_W-1:0] upd_line,
  input  logic [LVL_W-1:0]  upd_level,
  input  logic [WAY_W-1:0]  upd_way,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LVL_W-1:0]  rsp_route,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              refill_req,
  output logic [VPN_W-1:0]  refill_vpn,
  output logic              upd_drop
);
  import lttlb_pkg::*;

  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][LINES-1:0] known_q;

  logic [VPN_W-1:0]  lk_vpn;
  logic [LINE_W-1:0] lk_line;
  assign lk_vpn  = req_va[VA_W-1:PAGE_OFS_W];
  assign lk_line = req_va[PAGE_OFS_W-1:LINE_OFS_W];

  logic             lk_hit, up_hit, fl_hit;
  logic [IDX_W-1:0] lk_idx, up_idx, fl_idx, victim, fill_slot;

  lttlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_cam_lookup (
    .tags(tag_q), .valid(valid_q), .key(lk_vpn), .hit(lk_hit), .idx(lk_idx));
  lttlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_cam_update (
    .tags(tag_q), .valid(valid_q), .key(upd_vpn), .hit(up_hit), .idx(up_idx));
  lttlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_cam_fill (
    .tags(tag_q), .valid(valid_q), .key(fill_vpn), .hit(fl_hit), .idx(fl_idx));

  assign fill_slot = fl_hit ? fl_idx : victim;

  logic             touch;
  logic [IDX_W-1:0] touch_idx;
  assign touch     = fill_valid || (req_valid && lk_hit);
  assign touch_idx = fill_valid ? fill_slot : lk_idx;

  lttlb_lru #(.ENTRIES(ENTRIES)) i_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .valid(valid_q), .victim(victim));

  logic             upd_we;
  logic [REC_W-1:0] rec_q;
  assign upd_we = upd_valid && up_hit;

  lttlb_locmem #(.ADDR_W(IDX_W + LINE_W), .DATA_W(REC_W)) i_locmem (
    .clk(clk), .we(upd_we), .waddr({up_idx, upd_line}),
    .wdata({upd_level, upd_way}), .raddr({lk_idx, lk_line}), .rdata(rec_q));

  // Entry state: update first, refill of the same slot overrides it
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      known_q <= '0;
    end else begin
      if (upd_we) known_q[up_idx][upd_line] <= 1'b1;
      if (fill_valid) begin
        valid_q[fill_slot] <= 1'b1;
        known_q[fill_slot] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[fill_slot] <= fill_vpn;
      ppn_q[fill_slot] <= fill_ppn;
    end
  end

  // Response stage
  logic                  vld_r, hit_r, known_r, miss_r, drop_r;
  logic [PPN_W-1:0]      ppn_r;
  logic [PAGE_OFS_W-1:0] ofs_r;
  logic [VPN_W-1:0]      vpn_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_r  <= 1'b0;
      hit_r  <= 1'b0;
      miss_r <= 1'b0;
      drop_r <= 1'b0;
    end else begin
      vld_r  <= req_valid;
      hit_r  <= req_valid && lk_hit;
      miss_r <= req_valid && !lk_hit;
      drop_r <= upd_valid && !up_hit;
    end
  end

  always_ff @(posedge clk) begin
    known_r <= known_q[lk_idx][lk_line];
    ppn_r   <= ppn_q[lk_idx];
    ofs_r   <= req_va[PAGE_OFS_W-1:0];
    vpn_r   <= lk_vpn;
  end

  logic [LVL_W-1:0] rec_lvl;
  logic [WAY_W-1:0] rec_way;
  logic [LVL_W-1:0] route;
  assign rec_lvl = rec_q[REC_W-1:WAY_W];
  assign rec_way = rec_q[WAY_W-1:0];

  always_comb begin
    route = LVL_NONE;
    if (hit_r && known_r && (rec_lvl == LVL_L1 || rec_lvl == LVL_L2)) route = rec_lvl;
  end

  assign rsp_valid  = vld_r;
  assign rsp_hit    = hit_r;
  assign rsp_route  = route;
  assign rsp_way    = (route != LVL_NONE) ? rec_way : '0;
  assign rsp_pa     = hit_r ? {ppn_r, ofs_r} : '0;
  assign refill_req = miss_r;
  assign refill_vpn = miss_r ? vpn_r : '0;
  assign upd_drop   = drop_r;
endmodule

// File: rtl/lttlb_chk.sv
module lttlb_chk #(
  parameter int unsigned LVL_W = 2,
  parameter int unsigned WAY_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             upd_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [LVL_W-1:0] rsp_route,
  input logic [WAY_W-1:0] rsp_way,
  input logic             refill_req,
  input logic             upd_drop
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R3
  refill_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> (rsp_valid && !rsp_hit));
  // R3
  miss_goes_to_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_route == '0 && refill_req));
  // R6
  no_reserved_route_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_route != 2'b11));
  // R5
  mem_route_way_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == '0) |-> (rsp_way == '0));
  // R8
  drop_follows_update_chk: assert property (@(posedge clk) disable iff (rst)
    upd_drop |-> $past(upd_valid));
endmodule

bind lttlb_top lttlb_chk #(.LVL_W(LVL_W), .WAY_W(WAY_W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .upd_valid(upd_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_route(rsp_route),
  .rsp_way(rsp_way), .refill_req(refill_req), .upd_drop(upd_drop));

// File: tb/test_lttlb_top.sv
module test_lttlb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        upd_valid = 1'b0;
  logic [19:0] upd_vpn = '0;
  logic [5:0]  upd_line = '0;
  logic [1:0]  upd_level = '0;
  logic [2:0]  upd_way = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        rsp_valid, rsp_hit, refill_req, upd_drop;
  logic [1:0]  rsp_route;
  logic [2:0]  rsp_way;
  logic [31:0] rsp_pa;
  logic [19:0] refill_vpn;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lttlb_top i_lttlb_top (.*);

  localparam logic [1:0] OP_LOOK = 2'd0, OP_UPD = 2'd1, OP_FILL = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [5:0]  line;
    logic [1:0]  lvl;
    logic [2:0]  way;
    logic        e_hit;
    logic [1:0]  e_route;
    logic [2:0]  e_way;
    logic        e_flag;   // refill_req for lookups, upd_drop for updates
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{OP_LOOK, 20'h00010, 6'd0,  2'd0, 3'd0, 1'b0, 2'd0, 3'd0, 1'b1}, // R1 R3 miss
    '{OP_FILL, 20'h00010, 6'd0,  2'd0, 3'd0, 1'b0, 2'd0, 3'd0, 1'b0},
    '{OP_LOOK, 20'h00010, 6'd5,  2'd0, 3'd0, 1'b1, 2'd0, 3'd0, 1'b0}, // R4
    '{OP_UPD,  20'h00010, 6'd5,  2'd1, 3'd3, 1'b0, 2'd0, 3'd0, 1'b0}, // R7
    '{OP_LOOK, 20'h00010, 6'd5,  2'd0, 3'd0, 1'b1, 2'd1, 3'd3, 1'b0}, // R5 L1
    '{OP_LOOK, 20'h00010, 6'd6,  2'd0, 3'd0, 1'b1, 2'd0, 3'd0, 1'b0}, // R7 neighbour
    '{OP_UPD,  20'h00033, 6'd1,  2'd2, 3'd7, 1'b0, 2'd0, 3'd0, 1'b1}, // R8
    '{OP_LOOK, 20'h00033, 6'd1,  2'd0, 3'd0, 1'b0, 2'd0, 3'd0, 1'b1}, // R8 still absent
    '{OP_UPD,  20'h00010, 6'd63, 2'd2, 3'd7, 1'b0, 2'd0, 3'd0, 1'b0},
    '{OP_LOOK, 20'h00010, 6'd63, 2'd0, 3'd0, 1'b1, 2'd2, 3'd7, 1'b0}, // R5 L2
    '{OP_LOOK, 20'h00010, 6'd5,  2'd0, 3'd0, 1'b1, 2'd1, 3'd3, 1'b0}, // R7 kept
    '{OP_UPD,  20'h00010, 6'd5,  2'd3, 3'd2, 1'b0, 2'd0, 3'd0, 1'b0},
    '{OP_LOOK, 20'h00010, 6'd5,  2'd0, 3'd0, 1'b1, 2'd0, 3'd0, 1'b0}, // R6
    '{OP_UPD,  20'h00010, 6'd9,  2'd1, 3'd6, 1'b0, 2'd0, 3'd0, 1'b0},
    '{OP_UPD,  20'h00010, 6'd9,  2'd0, 3'd6, 1'b0, 2'd0, 3'd0, 1'b0},
    '{OP_LOOK, 20'h00010, 6'd9,  2'd0, 3'd0, 1'b1, 2'd0, 3'd0, 1'b0}  // R5 evicted
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] va_of(input logic [19:0] vpn, input logic [5:0] line);
    return {vpn, line, 6'h2C};
  endfunction

  task automatic idle_inputs();
    req_valid = 1'b0; upd_valid = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_look(input string req, input logic [19:0] vpn, input logic [5:0] line,
                         input logic e_hit, input logic [1:0] e_route, input logic [2:0] e_way,
                         input logic [19:0] e_ppn);
    @(negedge clk);
    req_valid = 1'b1; req_va = va_of(vpn, line);
    @(negedge clk);
    idle_inputs();
    check(req, {rsp_valid, rsp_hit, rsp_route, rsp_way}, {1'b1, e_hit, e_route, e_way});
    check(req, rsp_pa, e_hit ? {e_ppn, line, 6'h2C} : 32'h0);
    check(req, {refill_req, refill_vpn}, e_hit ? 21'h0 : {1'b1, vpn});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", {rsp_valid, refill_req, upd_drop}, 3'b000);

    // R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      case (VEC[v].op)
        OP_LOOK: begin req_valid = 1'b1; req_va = va_of(VEC[v].vpn, VEC[v].line); end
        OP_UPD: begin
          upd_valid = 1'b1; upd_vpn = VEC[v].vpn; upd_line = VEC[v].line;
          upd_level = VEC[v].lvl; upd_way = VEC[v].way;
        end
        default: begin fill_valid = 1'b1; fill_vpn = VEC[v].vpn; fill_ppn = 20'h000A0; end
      endcase
      @(negedge clk);
      idle_inputs();
      if (VEC[v].op == OP_LOOK) begin
        check("R2/R5 vector", {rsp_valid, rsp_hit, rsp_route, rsp_way},
              {1'b1, VEC[v].e_hit, VEC[v].e_route, VEC[v].e_way});
        check("R2 vector pa", rsp_pa,
              VEC[v].e_hit ? {20'h000A0, VEC[v].line, 6'h2C} : 32'h0);
        check("R3 vector refill", {refill_req, refill_vpn},
              VEC[v].e_flag ? {1'b1, VEC[v].vpn} : 21'h0);
      end else if (VEC[v].op == OP_UPD) begin
        check("R8 vector drop", {upd_drop, rsp_valid}, {VEC[v].e_flag, 1'b0});
      end
    end

    // R9 collision: lookup and update of the same line in one cycle
    @(negedge clk);
    req_valid = 1'b1; req_va = va_of(20'h00010, 6'd63);
    upd_valid = 1'b1; upd_vpn = 20'h00010; upd_line = 6'd63; upd_level = 2'd1; upd_way = 3'd1;
    @(negedge clk);
    idle_inputs();
    check("R9 old value", {rsp_hit, rsp_route, rsp_way}, {1'b1, 2'd2, 3'd7});
    do_look("R9 new value", 20'h00010, 6'd63, 1'b1, 2'd1, 3'd1, 20'h000A0);

    // R11 R4 refill of a resident page reuses slot and clears lines
    do_fill(20'h00010, 20'h000B0);
    do_look("R11 R4 cleared", 20'h00010, 6'd63, 1'b1, 2'd0, 3'd0, 20'h000B0);

    // R10 fill remaining 15 slots, touch the oldest, then evict
    for (int p = 0; p < 15; p++) do_fill(20'h00020 + 20'(p), 20'h00100 + 20'(p));
    do_look("R10 full hit", 20'h00010, 6'd1, 1'b1, 2'd0, 3'd0, 20'h000B0);
    do_fill(20'h00099, 20'h00199);
    do_look("R10 evicted", 20'h00020, 6'd2, 1'b0, 2'd0, 3'd0, 20'h0);
    do_look("R10 survivor", 20'h00021, 6'd2, 1'b1, 2'd0, 3'd0, 20'h00101);
    do_look("R10 new page", 20'h00099, 6'd3, 1'b1, 2'd0, 3'd0, 20'h00199);
    do_look("R10 touched kept", 20'h00010, 6'd3, 1'b1, 2'd0, 3'd0, 20'h000B0);

    // R2 no request -> no response
    @(negedge clk);
    check("R2 idle", {rsp_valid, refill_req, upd_drop}, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule